// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table that lives in ordinary memory. A base address register names the top-level table. The walker reads one word from that table and then one word from the second-level table that the first word points to. Each entry is checked for presence, and the leaf entry is also checked for write permission. The result is a physical address, a page-fault flag or a protection-fault flag, shown for one cycle with a done pulse.

When a store reaches a present, writable leaf entry that is still clean, the walker writes the entry back with its modified bit set before it reports done. Only one walk runs at a time. While a walk is running, the block shows busy and ignores new requests. Memory is reached through a request channel with a valid/ready handshake and a response channel that carries a response-valid strobe. A write has no response and completes on its handshake.

Virtual address split: bits 31:22 select the first-level entry, bits 21:12 select the second-level entry, and bits 11:0 are the page offset. Entry fields: bit 0 present, bit 1 modified, bit 2 writable, bits 31:14 physical page number (leaf). In a first-level entry, bits 31:12 give the 4 KB-aligned address of the second-level table.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: busy low, req_ready high, done low, fault flags low and mem_req_valid low.
- R2: The first memory read of a walk goes to ptbr + 4 × va[31:22], where ptbr is sampled when the request is accepted.
- R3: If bit 0 of the first-level entry is 0, the walk ends with fault_page high and no second read is made.
- R4: The second read goes to {L1[31:12], 12'h000} + 4 × va[21:12].
- R5: If bit 0 of the second-level entry is 0, the walk ends with fault_page high and makes no write.
- R6: On success, pa equals {L2[31:14], va[11:0]} and both fault flags are low.
- R7: A store whose leaf entry is present but has bit 2 clear ends with fault_prot high and makes no memory write.
- R8: A store whose leaf entry is present, writable (bit 2) and clean (bit 1 clear) makes exactly one write, to the leaf entry's address, with data equal to the entry with bit 1 set. This write happens before done.
- R9: A load, or a store to a leaf that is already modified, makes no memory write.
- R10: done is high for exactly one cycle per walk, and at most one fault flag is high with it.
- R11: busy is high from the cycle after acceptance through done. Requests offered while busy are ignored, and req_ready equals not busy.
- R12: A memory request that is not accepted holds its valid, address, write flag and data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_store | input | 1 | Access is a store (1) or a load (0) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| pa | output | 30 | Physical address result |
| fault_page | output | 1 | Entry not present |
| fault_prot | output | 1 | Store to a read-only page |

## Verification
The bench sweeps every first-level index, in both load and store passes, over tables whose present, writable and modified bits follow different periods. Every combination of fault, protection and modified-bit update occurs many times, including stores that find a page made dirty by an earlier walk. A design that used the wrong index bits or dropped the frame alignment would read the wrong addresses, and these are checked on every walk. A design that wrote a modified bit on a load, on a read-only page or on a page already dirty would show an unexpected write. One that checked write permission on loads would report false protection faults. The memory model stalls the request channel in a rotating pattern and offers a second request while a walk is busy. This exposes requests that change while stalled and walks that restart too early.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
   typedef enum logic [2:0] {
      WS_IDLE,
      WS_RD_TOP,
      WS_RD_LEAF,
      WS_WR_MOD,
      WS_DONE,
      WS_FAULT
   } walk_state_e;

   localparam int PTE_PRESENT_BIT  = 0;
   localparam int PTE_MODIFIED_BIT = 1;
   localparam int PTE_WRITABLE_BIT = 2;
endpackage

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
   parameter int DATA_W = 32,
   parameter int OFF_W  = 12,
   parameter int PPN_W  = 18
) (
   input  logic [DATA_W-1:0] entry,
   output logic              present,
   output logic              modified,
   output logic              writable,
   output logic [PPN_W-1:0]  ppn,
   output logic [DATA_W-1:0] frame
);
   import pt_walker_pkg::*;

   always_comb begin
      present  = entry[PTE_PRESENT_BIT];
      modified = entry[PTE_MODIFIED_BIT];
      writable = entry[PTE_WRITABLE_BIT];
      ppn      = entry[DATA_W-1 -: PPN_W];
      frame    = {entry[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
   end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
   parameter int AW    = 32,
   parameter int VA_W  = 32,
   parameter int IDX_W = 10,
   parameter int OFF_W = 12
) (
   input  logic [AW-1:0]   top_base,
   input  logic [AW-1:0]   leaf_base,
   input  logic [VA_W-1:0] va,
   input  logic            sel_leaf,
   output logic [AW-1:0]   addr
);
   localparam int PAD_W = AW - IDX_W - 2;

   logic [IDX_W-1:0] idx_top;
   logic [IDX_W-1:0] idx_leaf;
   logic [AW-1:0]    off_top;
   logic [AW-1:0]    off_leaf;

   always_comb begin
      idx_top  = va[VA_W-1 -: IDX_W];
      idx_leaf = va[OFF_W +: IDX_W];
      off_top  = {{PAD_W{1'b0}}, idx_top, 2'b00};
      off_leaf = {{PAD_W{1'b0}}, idx_leaf, 2'b00};
      addr     = sel_leaf ? (leaf_base + off_leaf) : (top_base + off_top);
   end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm #(
   parameter int AW        = 32,
   parameter int VA_W      = 32,
   parameter int DATA_W    = 32,
   parameter int OFF_W     = 12,
   parameter int PA_W      = 30,
   parameter bit SET_DIRTY = 1'b1,
   localparam int PPN_W    = PA_W - OFF_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [VA_W-1:0]         req_va,
   input  logic                    req_store,
   input  logic [AW-1:0]           ptbr,
   input  logic                    mem_req_ready,
   input  logic                    mem_rsp_valid,
   input  logic [DATA_W-1:0]       mem_rsp_rdata,
   input  logic                    rsp_present,
   input  logic                    rsp_modified,
   input  logic                    rsp_writable,
   input  logic [PPN_W-1:0]        rsp_ppn,
   input  logic [PPN_W-1:0]        leaf_ppn,
   output pt_walker_pkg::walk_state_e state,
   output logic                    issued,
   output logic [VA_W-1:0]         va_q,
   output logic [AW-1:0]           base_q,
   output logic [DATA_W-1:0]       top_q,
   output logic [DATA_W-1:0]       leaf_q,
   output logic [PA_W-1:0]         pa_q,
   output logic                    fpage_q,
   output logic                    fprot_q
);
   import pt_walker_pkg::*;

   logic store_q;
   logic fire;

   assign fire = mem_req_ready && !issued;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         issued  <= 1'b0;
         va_q    <= '0;
         base_q  <= '0;
         top_q   <= '0;
         leaf_q  <= '0;
         pa_q    <= '0;
         fpage_q <= 1'b0;
         fprot_q <= 1'b0;
         store_q <= 1'b0;
      end else begin
         case (state)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_va;
                  store_q <= req_store;
                  base_q  <= ptbr;
                  pa_q    <= '0;
                  fpage_q <= 1'b0;
                  fprot_q <= 1'b0;
                  issued  <= 1'b0;
                  state   <= WS_RD_TOP;
               end
            end
            WS_RD_TOP: begin
               if (fire) begin
                  issued <= 1'b1;
               end else if (issued && mem_rsp_valid) begin
                  issued <= 1'b0;
                  if (!rsp_present) begin
                     fpage_q <= 1'b1;
                     state   <= WS_FAULT;
                  end else begin
                     top_q <= mem_rsp_rdata;
                     state <= WS_RD_LEAF;
                  end
               end
            end
            WS_RD_LEAF: begin
               if (fire) begin
                  issued <= 1'b1;
               end else if (issued && mem_rsp_valid) begin
                  issued <= 1'b0;
                  leaf_q <= mem_rsp_rdata;
                  if (!rsp_present) begin
                     fpage_q <= 1'b1;
                     state   <= WS_FAULT;
                  end else if (store_q && !rsp_writable) begin
                     fprot_q <= 1'b1;
                     state   <= WS_FAULT;
                  end else if (SET_DIRTY && store_q && !rsp_modified) begin
                     state <= WS_WR_MOD;
                  end else begin
                     pa_q  <= {rsp_ppn, va_q[OFF_W-1:0]};
                     state <= WS_DONE;
                  end
               end
            end
            WS_WR_MOD: begin
               if (mem_req_ready) begin
                  pa_q  <= {leaf_ppn, va_q[OFF_W-1:0]};
                  state <= WS_DONE;
               end
            end
            WS_DONE:  state <= WS_IDLE;
            WS_FAULT: state <= WS_IDLE;
            default:  state <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int VA_W      = 32,
   parameter int IDX_W     = 10,
   parameter int OFF_W     = 12,
   parameter int PA_W      = 30,
   parameter int DATA_W    = 32,
   parameter int AW        = 32,
   parameter bit SET_DIRTY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ptbr,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_store,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [AW-1:0]     mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              done,
   output logic [PA_W-1:0]   pa,
   output logic              fault_page,
   output logic              fault_prot
);
   import pt_walker_pkg::*;

   localparam int PPN_W = PA_W - OFF_W;

   if (VA_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("pt_walker: VA_W must equal two indices plus the offset");
   end
   if (PA_W <= OFF_W) begin : g_bad_pa
      $error("pt_walker: PA_W must exceed OFF_W");
   end
   if (DATA_W - PPN_W < 3) begin : g_bad_entry
      $error("pt_walker: entry too narrow for flag bits");
   end
   if (AW != DATA_W) begin : g_bad_aw
      $error("pt_walker: table frame in entry must match address width");
   end

   walk_state_e       state;
   logic              issued;
   logic [VA_W-1:0]   va_q;
   logic [AW-1:0]     base_q;
   logic [DATA_W-1:0] top_q;
   logic [DATA_W-1:0] leaf_q;
   logic [PA_W-1:0]   pa_q;
   logic              fpage_q;
   logic              fprot_q;

   logic              rsp_present, rsp_modified, rsp_writable;
   logic [PPN_W-1:0]  rsp_ppn;
   logic [DATA_W-1:0] rsp_frame;
   logic              top_present, top_modified, top_writable;
   logic [PPN_W-1:0]  top_ppn;
   logic [DATA_W-1:0] top_frame;
   logic              leaf_present, leaf_modified, leaf_writable;
   logic [PPN_W-1:0]  leaf_ppn;
   logic [DATA_W-1:0] leaf_frame;

   pt_entry_decode #(.DATA_W(DATA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_dec_rsp (
      .entry(mem_rsp_rdata), .present(rsp_present), .modified(rsp_modified),
      .writable(rsp_writable), .ppn(rsp_ppn), .frame(rsp_frame)
   );

   pt_entry_decode #(.DATA_W(DATA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_dec_top (
      .entry(top_q), .present(top_present), .modified(top_modified),
      .writable(top_writable), .ppn(top_ppn), .frame(top_frame)
   );

   pt_entry_decode #(.DATA_W(DATA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_dec_leaf (
      .entry(leaf_q), .present(leaf_present), .modified(leaf_modified),
      .writable(leaf_writable), .ppn(leaf_ppn), .frame(leaf_frame)
   );

   pt_walk_fsm #(
      .AW(AW), .VA_W(VA_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
      .PA_W(PA_W), .SET_DIRTY(SET_DIRTY)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid && req_ready), .req_va(req_va), .req_store(req_store),
      .ptbr(ptbr), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .rsp_present(rsp_present), .rsp_modified(rsp_modified),
      .rsp_writable(rsp_writable), .rsp_ppn(rsp_ppn), .leaf_ppn(leaf_ppn),
      .state(state), .issued(issued), .va_q(va_q), .base_q(base_q),
      .top_q(top_q), .leaf_q(leaf_q), .pa_q(pa_q),
      .fpage_q(fpage_q), .fprot_q(fprot_q)
   );

   pt_addr_gen #(.AW(AW), .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
      .top_base(base_q), .leaf_base(top_frame), .va(va_q),
      .sel_leaf(state != WS_RD_TOP), .addr(mem_req_addr)
   );

   always_comb begin
      busy          = (state != WS_IDLE);
      req_ready     = !busy;
      mem_req_write = (state == WS_WR_MOD);
      mem_req_valid = ((state == WS_RD_TOP || state == WS_RD_LEAF) && !issued)
                      || mem_req_write;
      mem_req_wdata = leaf_q;
      mem_req_wdata[PTE_MODIFIED_BIT] = 1'b1;
      done          = (state == WS_DONE) || (state == WS_FAULT);
      pa            = pa_q;
      fault_page    = fpage_q;
      fault_prot    = fprot_q;
   end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int AW     = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              busy,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [AW-1:0]     mem_req_addr,
   input logic [DATA_W-1:0] mem_req_wdata,
   input logic              done,
   input logic              fault_page,
   input logic              fault_prot
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid && !done);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_one_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(fault_page && fault_prot));

   p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> busy);

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_write) && $stable(mem_req_wdata));

   p_write_sets_mod_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> mem_req_wdata[1] && mem_req_wdata[0]);

   p_prot_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault_prot |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
   .mem_req_wdata(mem_req_wdata), .done(done), .fault_page(fault_page),
   .fault_prot(fault_prot)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ptbr = 32'h0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = 32'h0;
   logic        req_store = 1'b0;
   logic        busy;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = 32'h0;
   logic        done;
   logic [29:0] pa;
   logic        fault_page;
   logic        fault_prot;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pt_walker u_dut (
      .clk(clk), .rst_n(rst_n), .ptbr(ptbr), .req_valid(req_valid),
      .req_ready(req_ready), .req_va(req_va), .req_store(req_store),
      .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .done(done), .pa(pa),
      .fault_page(fault_page), .fault_prot(fault_prot)
   );

   // memory model: 16 KB of words
   logic [31:0] mem [0:4095];
   int          rd_cnt, wr_cnt;
   logic [31:0] rd_addr0, rd_addr1, wr_addr, wr_data;
   logic        pend = 1'b0;
   logic [31:0] pend_data;
   int          tick = 0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(mem_req_valid && mem_req_addr == prev_addr, "R12 held request",
                  mem_req_addr, prev_addr);
         mem_rsp_valid = 1'b0;
         if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = pend_data;
            pend = 1'b0;
         end
         tick++;
         mem_req_ready = (tick % 3) != 1;
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               mem[mem_req_addr[13:2]] = mem_req_wdata;
               wr_cnt++;
               wr_addr = mem_req_addr;
               wr_data = mem_req_wdata;
            end else begin
               pend = 1'b1;
               pend_data = mem[mem_req_addr[13:2]];
               if (rd_cnt == 0) rd_addr0 = mem_req_addr;
               if (rd_cnt == 1) rd_addr1 = mem_req_addr;
               rd_cnt++;
            end
         end
      end
   end

   task automatic walk(input int i1, input int i2, input int off, input bit st,
                       input bit poke);
      logic [31:0] va, e1, e2, a1, a2, frame;
      bit exp_pf, exp_prot, exp_wr;
      int n_rd, wait_cyc;
      va = {i1[9:0], i2[9:0], off[11:0]};
      a1 = ptbr + i1 * 4;
      e1 = mem[a1[13:2]];
      frame = {e1[31:12], 12'h000};
      a2 = frame + i2 * 4;
      e2 = mem[a2[13:2]];
      exp_pf = 0; exp_prot = 0; exp_wr = 0; n_rd = 2;
      if (!e1[0]) begin exp_pf = 1; n_rd = 1; end
      else if (!e2[0]) exp_pf = 1;
      else if (st && !e2[2]) exp_prot = 1;
      else if (st && !e2[1]) exp_wr = 1;
      rd_cnt = 0; wr_cnt = 0;
      req_va = va; req_store = st; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         req_va = ~va; req_store = 1'b0; req_valid = 1'b1;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      wait_cyc = 0;
      while (!done && wait_cyc < 200) begin
         @(negedge clk);
         wait_cyc++;
      end
      check(done, "R10 walk completes", {31'h0, done}, 32'h1);
      check(rd_addr0 == a1, "R2 top read address", rd_addr0, a1);
      check(rd_cnt == n_rd, "R3 read count", rd_cnt, n_rd);
      if (n_rd == 2) check(rd_addr1 == a2, "R4 leaf read address", rd_addr1, a2);
      check(fault_page == exp_pf, exp_pf ? "R5 page fault" : "R3 page fault flag",
            {31'h0, fault_page}, {31'h0, exp_pf});
      check(fault_prot == exp_prot, "R7 protection fault", {31'h0, fault_prot},
            {31'h0, exp_prot});
      check(wr_cnt == (exp_wr ? 1 : 0), exp_wr ? "R8 dirty write count" : "R9 no write",
            wr_cnt, {31'h0, exp_wr});
      if (exp_wr) begin
         check(wr_addr == a2, "R8 dirty write address", wr_addr, a2);
         check(wr_data == (e2 | 32'h2), "R8 dirty write data", wr_data, e2 | 32'h2);
      end
      if (!exp_pf && !exp_prot)
         check(pa == {e2[31:14], off[11:0]}, "R6 physical address", {2'b0, pa},
               {2'b0, e2[31:14], off[11:0]});
      @(negedge clk);
      check(!done, "R10 done one cycle", {31'h0, done}, 32'h0);
      check(!busy && req_ready, "R11 idle after done", {31'h0, busy}, 32'h0);
      if (poke) begin
         repeat (3) @(negedge clk);
         check(!busy && !mem_req_valid, "R11 request during busy ignored",
               {31'h0, busy}, 32'h0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4096; k++) mem[k] = 32'h0;
      for (int i = 0; i < 1024; i++)
         mem[i] = ((1 + i % 3) << 12) | (((i % 4) != 3) ? 1 : 0);
      for (int f = 1; f <= 3; f++)
         for (int j = 0; j < 1024; j++) begin
            logic [17:0] ppn;
            ppn = 18'((f * 1024 + j) * 37);
            mem[f * 1024 + j] = {ppn, 11'h0, (((j + f) % 2) == 0), ((j % 3) == 0),
                                 ((j % 5) != 4)};
         end
      repeat (3) @(negedge clk);
      check(!busy && req_ready && !done && !mem_req_valid && !fault_page && !fault_prot,
            "R1 reset state", {31'h0, busy}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && req_ready && !mem_req_valid, "R1 idle after reset",
            {31'h0, mem_req_valid}, 32'h0);
      for (int i = 0; i < 1024; i++)
         walk(i, (i * 7 + 3) % 1024, (i * 13) % 4096, i[0], 1'b0);
      for (int i = 0; i < 1024; i++)
         walk(i, (i * 11 + 5) % 1024, (i * 29 + 1) % 4096, 1'b1, 1'b0);
      walk(5, (5 * 11 + 5) % 1024, 12'hABC, 1'b1, 1'b0);
      walk(1, 2, 12'h123, 1'b0, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule